// File: doc/BRIEF.md
# Serial Transmit Framer with Stick Parity and RTS Control

This block turns parallel words into asynchronous serial frames on a single TX line. A word arrives over a valid/ready handshake and is accepted only while the framer is idle. The framer then sends a low start bit, the data bits least significant first, an optional parity bit, and one or two high stop bits. Between frames the line rests high. Bit timing comes from an external baud tick: every bit lasts exactly 16 tick pulses. Without ticks, the current bit is held.

The control inputs set the word length (7, 8 or 9 bits), parity on or off, even or odd parity, stick parity (a parity bit forced to a fixed level), and one or two stop bits. The framer latches all of these at the start bit, so changing them during a frame has no effect on that frame. A break input holds the pin low while the framer keeps running underneath it. A separate path drives an active-low RTS pin. The source is either a software bit or a hardware flow-control request, and a readback output reports the current pin state.

The state machine has six states: `ST_IDLE`, `ST_START`, `ST_DATA`, `ST_PARITY`, `ST_STOP1` and `ST_STOP2`.
- `ST_IDLE` moves to `ST_START` when a word is accepted.
- `ST_START` moves to `ST_DATA` at the end of its bit.
- `ST_DATA` stays in place until the last data bit ends. It then moves to `ST_PARITY` if parity is active, or to `ST_STOP1` if not.
- `ST_PARITY` moves to `ST_STOP1` at the end of its bit.
- `ST_STOP1` moves to `ST_STOP2` if two stop bits are selected, or to `ST_IDLE` if not.
- `ST_STOP2` moves to `ST_IDLE`.

Top module: `uatx_framer`

## Requirements
- R1: The frame is one low start bit, then the data bits LSB first, then the optional parity bit, then the stop bits. The stop bits and the idle line are high.
- R2: Every bit lasts exactly 16 `baud_tick` pulses. While `baud_tick` stays low, the framer holds its current bit.
- R3: `in_ready` is high only in `ST_IDLE`. A word is taken on a clock edge where `in_valid` and `in_ready` are both high. The start bit appears on `tx_out` from the next cycle.
- R4: `cfg_wlen` selects the word length: 00 gives 7 bits, 01 gives 8 bits, 10 gives 9 bits, and 11 is treated as 8 bits. Input bits above the selected length are not sent.
- R5: With parity on and stick parity off, `cfg_par_even`=1 makes the data bits plus the parity bit hold an even number of ones. `cfg_par_even`=0 makes that count odd.
- R6: With parity on and stick parity on, the parity bit is 1 when `cfg_par_even`=0 and 0 when `cfg_par_even`=1.
- R7: With `cfg_par_en`=0, no parity bit is sent, whatever the values of `cfg_par_stick` and `cfg_par_even`.
- R8: With the 9-bit length selected, no parity bit is sent even when `cfg_par_en`=1.
- R9: `cfg_two_stop`=0 sends one stop bit and `cfg_two_stop`=1 sends two.
- R10: While `cfg_break`=1, `tx_out` is 0. The frame in progress keeps its timing, and `in_ready` returns high after the same number of bits as without the break.
- R11: With `cfg_hw_flow`=0, `rts_n` takes the value of NOT `cfg_rts_sw` one clock later.
- R12: With `cfg_hw_flow`=1, `rts_n` takes the value of NOT `hw_rts_req` one clock later and `cfg_rts_sw` is ignored. In both modes, `rts_state` reads back as NOT `rts_n`.
- R13: The framer latches the word-length, parity and stop settings when it accepts a word. Changing those inputs during the frame does not change the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | Oversampling tick; 16 pulses make one bit |
| in_valid | input | 1 | A word is offered |
| in_data | input | 9 | Word to send; bits above the selected length are ignored |
| in_ready | output | 1 | The framer is idle and will take a word |
| cfg_wlen | input | 2 | Word length select |
| cfg_par_en | input | 1 | Parity on |
| cfg_par_even | input | 1 | Even parity select; also sets the stick level |
| cfg_par_stick | input | 1 | Stick parity on |
| cfg_two_stop | input | 1 | Two stop bits |
| cfg_break | input | 1 | Hold the pin low |
| cfg_hw_flow | input | 1 | RTS driven by hardware request |
| cfg_rts_sw | input | 1 | Software RTS bit (1 drives the pin low) |
| hw_rts_req | input | 1 | Hardware RTS request (1 drives the pin low) |
| tx_out | output | 1 | Serial line |
| rts_n | output | 1 | Active-low RTS pin |
| rts_state | output | 1 | Readback of the RTS pin state (1 when the pin is low) |

## Verification
The bench targets the following corner cases, and what a faulty design would do in each:
- **Parity edge cases.** It sends all-zero and all-one words under odd, even and both stick settings. A parity generator with an inverted sense, or swapped stick levels, shows up at the parity bit position.
- **Conditions that drop the parity bit.** It runs frames with parity off but stick or even set, and frames with the 9-bit length and parity on. A design that still inserts a parity bit would put it where the stop bit should be.
- **Break.** A whole frame is sent under break. The bench checks that the line stays low and that `in_ready` returns on time, which catches a framer that stalls or restarts when the break is applied.
- **Stalls and mid-frame changes.** The baud tick is stopped during the start bit, and the settings are changed in the middle of a frame. A free-running bit counter, or settings that are not latched, would move or reshape the bits that follow.

// File: rtl/uatx_pkg.sv
package uatx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP1  = 3'd4,
        ST_STOP2  = 3'd5
    } tx_state_e;

    localparam logic [1:0] WL_7 = 2'b00;
    localparam logic [1:0] WL_8 = 2'b01;
    localparam logic [1:0] WL_9 = 2'b10;

    typedef struct packed {
        logic [1:0] wlen;
        logic       par_en;
        logic       par_even;
        logic       par_stick;
        logic       two_stop;
    } frame_cfg_t;

    // number of data bits for a length code; the spare code falls back to 8
    function automatic logic [3:0] data_bits(input logic [1:0] wl);
        logic [3:0] n;
        unique case (wl)
            WL_7:    n = 4'd7;
            WL_9:    n = 4'd9;
            default: n = 4'd8;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/uatx_baud_cnt.sv
module uatx_baud_cnt #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic bit_done
);
    localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign bit_done = tick && (cnt == LAST) && !clr;

endmodule

// File: rtl/uatx_parity.sv
module uatx_parity
    import uatx_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic [DATA_W-1:0] data,
    input  frame_cfg_t        cfg,
    output logic              par_bit,
    output logic              par_on
);
    logic [3:0]        nbits;
    logic [DATA_W-1:0] masked;
    logic              ones_odd;

    assign nbits = data_bits(cfg.wlen);

    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        assign masked[g] = data[g] & (4'(g) < nbits);
    end

    assign ones_odd = ^masked;
    // no parity slot in the 9-bit format
    assign par_on   = cfg.par_en && (cfg.wlen != WL_9);

    always_comb begin
        if (cfg.par_stick)     par_bit = ~cfg.par_even;
        else if (cfg.par_even) par_bit = ones_odd;
        else                   par_bit = ~ones_odd;
    end

endmodule

// File: rtl/uatx_rts.sv
module uatx_rts (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_mode,
    input  logic sw_bit,
    input  logic hw_req,
    output logic pin_n,
    output logic readback
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_n <= 1'b1;
        else        pin_n <= hw_mode ? ~hw_req : ~sw_bit;
    end

    assign readback = ~pin_n;

endmodule

// File: rtl/uatx_framer.sv
module uatx_framer
    import uatx_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    input  logic [1:0]        cfg_wlen,
    input  logic              cfg_par_en,
    input  logic              cfg_par_even,
    input  logic              cfg_par_stick,
    input  logic              cfg_two_stop,
    input  logic              cfg_break,
    input  logic              cfg_hw_flow,
    input  logic              cfg_rts_sw,
    input  logic              hw_rts_req,
    output logic              tx_out,
    output logic              rts_n,
    output logic              rts_state
);
    tx_state_e         state, state_nx;
    frame_cfg_t        cfg_in, cfg_q;
    logic [DATA_W-1:0] shreg;
    logic [3:0]        idx;
    logic [3:0]        nbits_q;
    logic              par_q, par_on_q;
    logic              par_bit_w, par_on_w;
    logic              bit_done, accept, last_data, line;

    assign cfg_in  = '{wlen: cfg_wlen, par_en: cfg_par_en, par_even: cfg_par_even,
                       par_stick: cfg_par_stick, two_stop: cfg_two_stop};
    assign accept  = (state == ST_IDLE) && in_valid;
    assign nbits_q = data_bits(cfg_q.wlen);
    assign last_data = (idx == nbits_q - 4'd1);

    uatx_baud_cnt #(.OVS(OVS)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(accept), .tick(baud_tick), .bit_done(bit_done)
    );

    uatx_parity #(.DATA_W(DATA_W)) u_par (
        .data(in_data), .cfg(cfg_in), .par_bit(par_bit_w), .par_on(par_on_w)
    );

    uatx_rts u_rts (
        .clk(clk), .rst_n(rst_n), .hw_mode(cfg_hw_flow), .sw_bit(cfg_rts_sw),
        .hw_req(hw_rts_req), .pin_n(rts_n), .readback(rts_state)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (in_valid) state_nx = ST_START;
            ST_START:  if (bit_done) state_nx = ST_DATA;
            ST_DATA:   if (bit_done && last_data)
                           state_nx = par_on_q ? ST_PARITY : ST_STOP1;
            ST_PARITY: if (bit_done) state_nx = ST_STOP1;
            ST_STOP1:  if (bit_done) state_nx = cfg_q.two_stop ? ST_STOP2 : ST_IDLE;
            ST_STOP2:  if (bit_done) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // frame datapath: latched word, settings and parity
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            idx      <= '0;
            cfg_q    <= '0;
            par_q    <= 1'b0;
            par_on_q <= 1'b0;
        end else if (accept) begin
            shreg    <= in_data;
            idx      <= '0;
            cfg_q    <= cfg_in;
            par_q    <= par_bit_w;
            par_on_q <= par_on_w;
        end else if (state == ST_DATA && bit_done) begin
            shreg <= shreg >> 1;
            idx   <= idx + 4'd1;
        end
    end

    // outputs
    always_comb begin
        in_ready = 1'b0;
        line     = 1'b1;
        unique case (state)
            ST_IDLE:   in_ready = 1'b1;
            ST_START:  line = 1'b0;
            ST_DATA:   line = shreg[0];
            ST_PARITY: line = par_q;
            ST_STOP1,
            ST_STOP2:  line = 1'b1;
            default:   line = 1'b1;
        endcase
        tx_out = cfg_break ? 1'b0 : line;
    end

endmodule

// File: rtl/uatx_framer_chk.sv
module uatx_framer_chk (
    input logic clk,
    input logic rst_n,
    input logic baud_tick,
    input logic in_valid,
    input logic in_ready,
    input logic cfg_break,
    input logic cfg_hw_flow,
    input logic cfg_rts_sw,
    input logic hw_rts_req,
    input logic tx_out,
    input logic rts_n
);
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !cfg_break) |-> tx_out);

    p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (!in_ready && (cfg_break || !tx_out)));

    p_hold_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!baud_tick && !in_ready) |=> !in_ready);

    p_hold_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!baud_tick && !in_ready && !cfg_break) |=> ($stable(tx_out) || cfg_break));

    p_break_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_break |-> !tx_out);

    p_sw_rts_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_hw_flow |=> (rts_n == !$past(cfg_rts_sw)));

    p_hw_rts_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_hw_flow |=> (rts_n == !$past(hw_rts_req)));

endmodule

bind uatx_framer uatx_framer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .in_valid(in_valid),
    .in_ready(in_ready), .cfg_break(cfg_break), .cfg_hw_flow(cfg_hw_flow),
    .cfg_rts_sw(cfg_rts_sw), .hw_rts_req(hw_rts_req), .tx_out(tx_out), .rts_n(rts_n)
);

// File: tb/sim_uatx_framer.sv
`timescale 1ns/1ps
module sim_uatx_framer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b1;
    logic       in_valid = 1'b0;
    logic [8:0] in_data = '0;
    logic       in_ready;
    logic [1:0] cfg_wlen = 2'b01;
    logic       cfg_par_en = 0, cfg_par_even = 0, cfg_par_stick = 0, cfg_two_stop = 0;
    logic       cfg_break = 0, cfg_hw_flow = 0, cfg_rts_sw = 0, hw_rts_req = 0;
    logic       tx_out, rts_n, rts_state;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    uatx_framer u0 (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .cfg_wlen(cfg_wlen),
        .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
        .cfg_par_stick(cfg_par_stick), .cfg_two_stop(cfg_two_stop),
        .cfg_break(cfg_break), .cfg_hw_flow(cfg_hw_flow), .cfg_rts_sw(cfg_rts_sw),
        .hw_rts_req(hw_rts_req), .tx_out(tx_out), .rts_n(rts_n), .rts_state(rts_state)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // sends one word and checks every bit in its middle
    task automatic run_frame(input logic [8:0] d, input logic [1:0] wl, input bit pe,
                             input bit ev, input bit st, input bit two, input bit brk,
                             input bit flip, input string req);
        bit exp_bits[16];
        int nb, n, ones;
        nb = (wl == 2'b00) ? 7 : (wl == 2'b10) ? 9 : 8;
        n = 0; ones = 0;
        exp_bits[n++] = 1'b0;
        for (int i = 0; i < nb; i++) begin
            exp_bits[n++] = d[i];
            ones += d[i];
        end
        if (pe && wl != 2'b10)
            exp_bits[n++] = st ? !ev : (ev ? ones[0] : !ones[0]);
        exp_bits[n++] = 1'b1;
        if (two) exp_bits[n++] = 1'b1;
        @(negedge clk);
        cfg_wlen = wl; cfg_par_en = pe; cfg_par_even = ev; cfg_par_stick = st;
        cfg_two_stop = two; cfg_break = brk;
        in_data = d; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        if (flip) begin
            cfg_wlen = (wl == 2'b10) ? 2'b00 : 2'b10; cfg_par_en = !pe;
            cfg_par_even = !ev; cfg_par_stick = !st; cfg_two_stop = !two;
        end
        repeat (8) @(negedge clk);
        check(in_ready == 1'b0, {req, " busy R3"}, in_ready, 0);
        for (int b = 0; b < n; b++) begin
            if (b > 0) repeat (16) @(negedge clk);
            check(tx_out == (brk ? 1'b0 : exp_bits[b]), req, tx_out, brk ? 0 : exp_bits[b]);
        end
        repeat (8) @(negedge clk);
        check(in_ready == 1'b1, {req, " length R9"}, in_ready, 1);
        cfg_break = 1'b0;
        cfg_two_stop = 1'b0;
        #0;
        check(tx_out == 1'b1, {req, " idle R1"}, tx_out, 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(in_ready == 1'b1, "R3 reset ready", in_ready, 1);
        check(tx_out == 1'b1, "R1 reset idle", tx_out, 1);
        check(rts_n == 1'b1, "R11 reset rts", rts_n, 1);
    endtask

    task automatic t_stall();
        @(negedge clk);
        cfg_wlen = 2'b01; cfg_par_en = 0; cfg_two_stop = 0;
        in_data = 9'h001; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; baud_tick = 1'b0;
        repeat (60) @(negedge clk);
        check(tx_out == 1'b0, "R2 stall start", tx_out, 0);
        check(in_ready == 1'b0, "R2 stall busy", in_ready, 0);
        baud_tick = 1'b1;
        repeat (8) @(negedge clk);
        check(tx_out == 1'b0, "R2 resume start", tx_out, 0);
        repeat (16) @(negedge clk);
        check(tx_out == 1'b1, "R2 resume bit0", tx_out, 1);
        repeat (16) @(negedge clk);
        check(tx_out == 1'b0, "R2 resume bit1", tx_out, 0);
        repeat (16 * 8) @(negedge clk);
        check(in_ready == 1'b1, "R2 stall end", in_ready, 1);
    endtask

    task automatic t_rts_sw();
        @(negedge clk);
        cfg_hw_flow = 0; cfg_rts_sw = 1; hw_rts_req = 0;
        @(negedge clk);
        check(rts_n == 1'b0, "R11 sw=1", rts_n, 0);
        check(rts_state == 1'b1, "R12 readback sw", rts_state, 1);
        cfg_rts_sw = 0; hw_rts_req = 1;
        @(negedge clk);
        check(rts_n == 1'b1, "R11 sw=0", rts_n, 1);
    endtask

    task automatic t_rts_hw();
        @(negedge clk);
        cfg_hw_flow = 1; cfg_rts_sw = 0; hw_rts_req = 1;
        @(negedge clk);
        check(rts_n == 1'b0, "R12 hw req", rts_n, 0);
        check(rts_state == 1'b1, "R12 readback hw", rts_state, 1);
        cfg_rts_sw = 1; hw_rts_req = 0;
        @(negedge clk);
        check(rts_n == 1'b1, "R12 sw ignored", rts_n, 1);
        check(rts_state == 1'b0, "R12 readback low", rts_state, 0);
        cfg_hw_flow = 0; cfg_rts_sw = 0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        run_frame(9'h0A5, 2'b01, 0, 0, 0, 0, 0, 0, "R1 8N1");
        run_frame(9'h07F, 2'b00, 0, 0, 0, 0, 0, 0, "R4 7-bit");
        run_frame(9'h1C3, 2'b10, 0, 0, 0, 0, 0, 0, "R4 9-bit");
        run_frame(9'h1FF, 2'b11, 0, 0, 0, 0, 0, 0, "R4 spare code");
        run_frame(9'h0B1, 2'b01, 1, 1, 0, 0, 0, 0, "R5 even");
        run_frame(9'h0B1, 2'b01, 1, 0, 0, 0, 0, 0, "R5 odd");
        run_frame(9'h000, 2'b01, 1, 0, 0, 0, 0, 0, "R5 odd zero");
        run_frame(9'h07F, 2'b00, 1, 1, 0, 0, 0, 0, "R5 even 7-bit");
        run_frame(9'h0FF, 2'b01, 1, 0, 1, 0, 0, 0, "R6 stick one");
        run_frame(9'h000, 2'b01, 1, 1, 1, 0, 0, 0, "R6 stick zero");
        run_frame(9'h033, 2'b01, 0, 1, 1, 0, 0, 0, "R7 parity off");
        run_frame(9'h155, 2'b10, 1, 1, 0, 0, 0, 0, "R8 9-bit no parity");
        run_frame(9'h03C, 2'b01, 1, 0, 0, 1, 0, 0, "R9 two stop");
        run_frame(9'h05A, 2'b01, 1, 1, 0, 1, 1, 0, "R10 break");
        run_frame(9'h0C6, 2'b01, 0, 0, 0, 0, 0, 1, "R13 hold cfg");
        run_frame(9'h129, 2'b10, 1, 0, 0, 1, 0, 1, "R13 hold cfg 9");
        t_stall();
        t_rts_sw();
        t_rts_hw();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule